// File: doc/BRIEF.md
# Linear CCD Drive Timing Generator

This block produces all digital drive waveforms for a three-colour, staggered-pixel linear CCD from a single master clock. It generates four shift-register phases, a reset-gate pulse, a clamp pulse, the transfer-gate pulse and a resolution-select level. Alongside these it reports the current pixel slot, a tag for the region that slot belongs to, and a line-valid flag for the downstream video capture.

The controller fixes its settings when it accepts a line-start strobe. These settings are the resolution (2400, 1200, 600 or 300 dpi), the clamp style (per-pixel or per-line), the phase half-period and the transfer-gate width in master clocks, and the minimum line period. At the lower resolutions only odd pixels are read out. The reset gate fires only once for every 1, 2 or 4 odd pixels, so the charges of those pixels add up on the output node. Around the transfer-gate pulse the phases stay frozen for a guard time. The guard time and the legal rate limits are parameters given in nanoseconds or MHz and turned into clock counts. If a setting breaks a rate or width limit, the block raises a flag and does not start a line with that setting.

Top module: `ccd_drive_tg`

## Requirements
- R1: `cfg_res` is encoded 0=2400, 1=1200, 2=600, 3=300 dpi and is latched on an accepted strobe. `res_sel` is high exactly when the latched resolution is 2400 dpi. Out of reset it is high.
- R2: Readout tags each slot with `region` (1=dummy, 2=optical black, 3=invalid, 4=valid, 0=not reading). The order is dummy, black, leading invalid, valid, trailing invalid. The counts are 56/96/8/21360/4 at 2400 dpi. Each lower mode halves the previous counts, with a floor of one.
- R3: One reset pulse per slot. A slot spans 1, 2, 4 or 8 phase half-periods for 2400, 1200, 600 and 300 dpi. This gives two resets per phase period at 2400 dpi, and one reset per 1, 2 or 4 odd pixels below that.
- R4: `sh_phi2` is the inverse of `sh_phi1`, and `sh_phi4` is the inverse of `sh_phi3`. During readout the phases toggle every `cfg_half` clocks, starting with `sh_phi1` high. Outside readout `sh_phi1` is held high.
- R5: After an accepted strobe, `xfer_gate` goes high after HOLD clocks, stays high for exactly `cfg_tg` clocks, and is followed by HOLD more frozen clocks before readout. HOLD defaults to 200 (1000 ns at 200 MHz).
- R6: Throughout the guard and transfer window, `rst_gate` is high. `clamp` is high in per-pixel mode (`cfg_bitclamp`=1) and low during `xfer_gate` in per-line mode.
- R7: During readout in per-pixel mode, a clamp pulse follows each reset pulse in every slot. In per-line mode, `clamp` is the inverse of `xfer_gate`.
- R8: `line_valid` is high exactly in valid-region slots. It is low for the entire first line whose latched resolution differs from that of the previous line.
- R9: A strobe is accepted only when idle and at least the previous latched `cfg_line` clocks after the previous accepted strobe. A strobe with legal settings that is not accepted raises `overrun` for one cycle and changes nothing else.
- R10: `cfg_err` is high when `cfg_half` is below 23 clocks (4.5 MHz phases), when the reset period is below 20 clocks (10 MHz), or when `cfg_tg` lies outside 1000..10000 clocks. A strobe seen while `cfg_err` is high is ignored.
- R11: `pix_idx` counts slots from 0 to N-1 through readout and is 0 outside it.
- R12: After reset the block is idle: transfer gate, reset gate and clamp are low, `sh_phi1` is high, region is 0, `line_valid` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Line-start strobe |
| cfg_res | input | 2 | Resolution code |
| cfg_bitclamp | input | 1 | 1 = per-pixel clamp, 0 = per-line clamp |
| cfg_half | input | 8 | Phase half-period in clocks |
| cfg_tg | input | 16 | Transfer-gate width in clocks |
| cfg_line | input | 24 | Minimum line period in clocks |
| sh_phi1 | output | 1 | Shift phase 1 |
| sh_phi2 | output | 1 | Shift phase 2 |
| sh_phi3 | output | 1 | Shift phase 3 |
| sh_phi4 | output | 1 | Shift phase 4 |
| rst_gate | output | 1 | Reset-gate pulse |
| clamp | output | 1 | Clamp pulse |
| xfer_gate | output | 1 | Transfer-gate pulse |
| res_sel | output | 1 | Resolution-select level |
| pix_idx | output | 16 | Slot index within the line |
| region | output | 3 | Region tag of the current slot |
| line_valid | output | 1 | Valid-pixel flag |
| overrun | output | 1 | Early-strobe pulse |
| cfg_err | output | 1 | Settings break a limit |

## Verification
Lines are run in each of the four resolutions, in both clamp styles, with random phase half-periods and gate widths. For every line the bench tallies the clocks spent in each region, the reset, clamp and phase edges, and the valid flag. Resolution sequences such as 2400→1200→1200→600→300→300 check that blanking follows only a change of resolution and never a repeated one. Strobes sent during a line, and strobes sent after the line but inside the line period, check that overrun does not disturb the running line. Settings just at the legal limits and just outside them check the rejection rule.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

    localparam int PIX_W  = 16;
    localparam int HALF_W = 8;
    localparam int TG_W   = 16;
    localparam int LINE_W = 24;
    localparam int CNT_W  = 16;

    typedef enum logic [1:0] {
        RES_2400 = 2'd0,
        RES_1200 = 2'd1,
        RES_600  = 2'd2,
        RES_300  = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        RG_IDLE  = 3'd0,
        RG_DUMMY = 3'd1,
        RG_OBLK  = 3'd2,
        RG_INVAL = 3'd3,
        RG_VALID = 3'd4
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_XFER = 3'd2,
        ST_POST = 3'd3,
        ST_READ = 3'd4
    } line_st_e;

    typedef struct packed {
        logic [PIX_W-1:0] dummy;
        logic [PIX_W-1:0] oblk;
        logic [PIX_W-1:0] lead;
        logic [PIX_W-1:0] valid;
        logic [PIX_W-1:0] trail;
    } layout_t;

    // phase half-periods per output slot (one reset per slot)
    function automatic logic [3:0] halves_per_slot(res_e r);
        return 4'd1 << r;
    endfunction

    // region count at a reduced resolution, never below one slot
    function automatic logic [PIX_W-1:0] scale_cnt(int unsigned base, res_e r);
        int unsigned v;
        v = base >> r;
        if (v == 0) v = 1;
        return v[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/ccd_region_map.sv
module ccd_region_map
    import ccd_tg_pkg::*;
#(
    parameter int unsigned DUMMY_PIX = 56,
    parameter int unsigned OBLK_PIX  = 96,
    parameter int unsigned LEAD_PIX  = 8,
    parameter int unsigned VALID_PIX = 21360,
    parameter int unsigned TRAIL_PIX = 4
) (
    input  res_e             res,
    input  logic [PIX_W-1:0] pix,
    output region_e          region,
    output logic [PIX_W-1:0] n_total
);

    layout_t          lay;
    logic [PIX_W-1:0] b_oblk, b_lead, b_valid, b_trail;

    always_comb begin
        lay.dummy = scale_cnt(DUMMY_PIX, res);
        lay.oblk  = scale_cnt(OBLK_PIX, res);
        lay.lead  = scale_cnt(LEAD_PIX, res);
        lay.valid = scale_cnt(VALID_PIX, res);
        lay.trail = scale_cnt(TRAIL_PIX, res);

        b_oblk  = lay.dummy;
        b_lead  = b_oblk + lay.oblk;
        b_valid = b_lead + lay.lead;
        b_trail = b_valid + lay.valid;
        n_total = b_trail + lay.trail;

        if (pix < b_oblk)       region = RG_DUMMY;
        else if (pix < b_lead)  region = RG_OBLK;
        else if (pix < b_valid) region = RG_INVAL;
        else if (pix < b_trail) region = RG_VALID;
        else                    region = RG_INVAL;
    end

endmodule

// File: rtl/ccd_phase_seq.sv
module ccd_phase_seq
    import ccd_tg_pkg::*;
#(
    parameter int unsigned RST_W = 4,
    parameter int unsigned CLP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    input  logic [3:0]        halves,
    input  logic [PIX_W-1:0]  n_total,
    output logic              ph,
    output logic              rst_win,
    output logic              clp_win,
    output logic [PIX_W-1:0]  pix,
    output logic              last
);

    localparam logic [HALF_W-1:0] RW_END = HALF_W'(RST_W);
    localparam logic [HALF_W-1:0] CW_END = HALF_W'(RST_W + CLP_W);

    logic [HALF_W-1:0] hc;
    logic [2:0]        hi;
    logic              half_end, slot_end;

    assign half_end = (hc == half - HALF_W'(1));
    assign slot_end = half_end && ({1'b0, hi} == halves - 4'd1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hc  <= '0;
            hi  <= '0;
            pix <= '0;
            ph  <= 1'b1;
        end else if (half_end) begin
            hc <= '0;
            ph <= ~ph;
            if (slot_end) begin
                hi  <= '0;
                pix <= pix + PIX_W'(1);
            end else begin
                hi <= hi + 3'd1;
            end
        end else begin
            hc <= hc + HALF_W'(1);
        end
    end

    assign last    = run && slot_end && (pix == n_total - PIX_W'(1));
    assign rst_win = (hi == 3'd0) && (hc < RW_END);
    assign clp_win = (hi == 3'd0) && (hc >= RW_END) && (hc < CW_END);

endmodule

// File: rtl/ccd_line_ctrl.sv
module ccd_line_ctrl
    import ccd_tg_pkg::*;
#(
    parameter int unsigned HOLD_CLKS = 200,
    parameter int unsigned HALF_MIN  = 23,
    parameter int unsigned RST_MIN   = 20,
    parameter int unsigned TG_MIN    = 1000,
    parameter int unsigned TG_MAX    = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  res_e              cfg_res,
    input  logic              cfg_bitclamp,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [TG_W-1:0]   cfg_tg,
    input  logic [LINE_W-1:0] cfg_line,
    input  logic              read_last,
    output line_st_e          state,
    output res_e              res_lat,
    output logic              bit_lat,
    output logic [HALF_W-1:0] half_lat,
    output logic              blank,
    output logic              overrun,
    output logic              cfg_err
);

    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CLKS - 1);

    logic [CNT_W-1:0]    cnt;
    logic [TG_W-1:0]     tg_lat;
    logic [LINE_W-1:0]   line_lat, elapsed;
    logic [HALF_W+3:0]   rst_period;
    logic                accept;

    always_comb begin
        rst_period = (HALF_W+4)'(cfg_half) * (HALF_W+4)'(halves_per_slot(cfg_res));
        cfg_err = (cfg_half < HALF_W'(HALF_MIN))
               || (rst_period < (HALF_W+4)'(RST_MIN))
               || (cfg_tg < TG_W'(TG_MIN))
               || (cfg_tg > TG_W'(TG_MAX));
        accept = strobe && !cfg_err && (state == ST_IDLE) && (elapsed >= line_lat);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            res_lat  <= RES_2400;
            bit_lat  <= 1'b1;
            half_lat <= HALF_W'(HALF_MIN);
            tg_lat   <= TG_W'(TG_MIN);
            line_lat <= '0;
            elapsed  <= '1;
            blank    <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            overrun <= strobe && !cfg_err && !accept;
            if (accept)              elapsed <= LINE_W'(1);
            else if (elapsed != '1)  elapsed <= elapsed + LINE_W'(1);

            case (state)
                ST_IDLE: if (accept) begin
                    state    <= ST_PRE;
                    cnt      <= '0;
                    blank    <= (cfg_res != res_lat);
                    res_lat  <= cfg_res;
                    bit_lat  <= cfg_bitclamp;
                    half_lat <= cfg_half;
                    tg_lat   <= cfg_tg;
                    line_lat <= cfg_line;
                end
                ST_PRE: if (cnt == HOLD_LAST) begin
                    state <= ST_XFER;
                    cnt   <= '0;
                end else cnt <= cnt + CNT_W'(1);
                ST_XFER: if (cnt == tg_lat - TG_W'(1)) begin
                    state <= ST_POST;
                    cnt   <= '0;
                end else cnt <= cnt + CNT_W'(1);
                ST_POST: if (cnt == HOLD_LAST) begin
                    state <= ST_READ;
                    cnt   <= '0;
                end else cnt <= cnt + CNT_W'(1);
                ST_READ: if (read_last) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ccd_drive_tg.sv
module ccd_drive_tg
    import ccd_tg_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 200,
    parameter int unsigned HOLD_NS   = 1000,
    parameter int unsigned TG_MIN_US = 5,
    parameter int unsigned TG_MAX_US = 50,
    parameter int unsigned RST_W     = 4,
    parameter int unsigned CLP_W     = 4,
    parameter int unsigned DUMMY_PIX = 56,
    parameter int unsigned OBLK_PIX  = 96,
    parameter int unsigned LEAD_PIX  = 8,
    parameter int unsigned VALID_PIX = 21360,
    parameter int unsigned TRAIL_PIX = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        line_start,
    input  logic [1:0]  cfg_res,
    input  logic        cfg_bitclamp,
    input  logic [7:0]  cfg_half,
    input  logic [15:0] cfg_tg,
    input  logic [23:0] cfg_line,
    output logic        sh_phi1,
    output logic        sh_phi2,
    output logic        sh_phi3,
    output logic        sh_phi4,
    output logic        rst_gate,
    output logic        clamp,
    output logic        xfer_gate,
    output logic        res_sel,
    output logic [15:0] pix_idx,
    output logic [2:0]  region,
    output logic        line_valid,
    output logic        overrun,
    output logic        cfg_err
);

    localparam int unsigned CLK_KHZ   = CLK_MHZ * 1000;
    localparam int unsigned HALF_MIN  = (CLK_KHZ + 8999) / 9000;   // 4.5 MHz phase ceiling
    localparam int unsigned RST_MIN   = (CLK_KHZ + 9999) / 10000;  // 10 MHz reset ceiling
    localparam int unsigned HOLD_CLKS = HOLD_NS * CLK_MHZ / 1000;
    localparam int unsigned TG_MIN    = TG_MIN_US * CLK_MHZ;
    localparam int unsigned TG_MAX    = TG_MAX_US * CLK_MHZ;

    line_st_e          state;
    res_e              res_lat;
    logic              bit_lat, blank, reading, holding;
    logic [HALF_W-1:0] half_lat;
    logic              ph, rst_win, clp_win, read_last;
    logic [PIX_W-1:0]  pix, n_total;
    region_e           map_region;

    ccd_line_ctrl #(
        .HOLD_CLKS(HOLD_CLKS), .HALF_MIN(HALF_MIN), .RST_MIN(RST_MIN),
        .TG_MIN(TG_MIN), .TG_MAX(TG_MAX)
    ) i_ctrl (
        .clk(clk), .rst(rst), .strobe(line_start),
        .cfg_res(res_e'(cfg_res)), .cfg_bitclamp(cfg_bitclamp),
        .cfg_half(cfg_half), .cfg_tg(cfg_tg), .cfg_line(cfg_line),
        .read_last(read_last), .state(state), .res_lat(res_lat),
        .bit_lat(bit_lat), .half_lat(half_lat), .blank(blank),
        .overrun(overrun), .cfg_err(cfg_err)
    );

    ccd_phase_seq #(.RST_W(RST_W), .CLP_W(CLP_W)) i_seq (
        .clk(clk), .rst(rst), .run(reading), .half(half_lat),
        .halves(halves_per_slot(res_lat)), .n_total(n_total),
        .ph(ph), .rst_win(rst_win), .clp_win(clp_win), .pix(pix), .last(read_last)
    );

    ccd_region_map #(
        .DUMMY_PIX(DUMMY_PIX), .OBLK_PIX(OBLK_PIX), .LEAD_PIX(LEAD_PIX),
        .VALID_PIX(VALID_PIX), .TRAIL_PIX(TRAIL_PIX)
    ) i_map (
        .res(res_lat), .pix(pix), .region(map_region), .n_total(n_total)
    );

    always_comb begin
        reading   = (state == ST_READ);
        holding   = (state == ST_PRE) || (state == ST_XFER) || (state == ST_POST);
        xfer_gate = (state == ST_XFER);
        sh_phi1   = ph;
        sh_phi2   = ~ph;
        sh_phi3   = ph;
        sh_phi4   = ~ph;
        rst_gate  = holding || (reading && rst_win);
        clamp     = bit_lat ? (holding || (reading && clp_win)) : ~xfer_gate;
        res_sel   = (res_lat == RES_2400);
        pix_idx   = reading ? pix : '0;
        region    = reading ? map_region : RG_IDLE;
        line_valid = reading && (map_region == RG_VALID) && !blank;
    end

endmodule

// File: rtl/ccd_drive_tg_chk.sv
module ccd_drive_tg_chk (
    input logic        clk,
    input logic        rst,
    input logic        line_start,
    input logic        sh_phi1,
    input logic        sh_phi2,
    input logic        sh_phi3,
    input logic        sh_phi4,
    input logic        rst_gate,
    input logic        clamp,
    input logic        xfer_gate,
    input logic [15:0] pix_idx,
    input logic [2:0]  region,
    input logic        line_valid,
    input logic        overrun,
    input logic        cfg_err,
    input logic        bit_lat
);

    a_r4_phase_pairs: assert property (@(posedge clk) disable iff (rst)
        (sh_phi1 != sh_phi2) && (sh_phi3 != sh_phi4));

    a_r5_frozen_in_xfer: assert property (@(posedge clk) disable iff (rst)
        xfer_gate |-> (sh_phi1 && region == 3'd0));

    a_r6_reset_high_xfer: assert property (@(posedge clk) disable iff (rst)
        xfer_gate |-> rst_gate);

    a_r6_bit_clamp_high: assert property (@(posedge clk) disable iff (rst)
        (xfer_gate && bit_lat) |-> clamp);

    a_r6_line_clamp_low: assert property (@(posedge clk) disable iff (rst)
        (xfer_gate && !bit_lat) |-> !clamp);

    a_r8_valid_in_region: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> (region == 3'd4));

    a_r9_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(line_start));

    a_r10_err_no_overrun: assert property (@(posedge clk) disable iff (rst)
        (line_start && cfg_err) |=> !overrun);

    a_r11_idle_index: assert property (@(posedge clk) disable iff (rst)
        (region == 3'd0) |-> (pix_idx == 16'd0));

endmodule

bind ccd_drive_tg ccd_drive_tg_chk i_chk (
    .clk(clk), .rst(rst), .line_start(line_start),
    .sh_phi1(sh_phi1), .sh_phi2(sh_phi2), .sh_phi3(sh_phi3), .sh_phi4(sh_phi4),
    .rst_gate(rst_gate), .clamp(clamp), .xfer_gate(xfer_gate),
    .pix_idx(pix_idx), .region(region), .line_valid(line_valid),
    .overrun(overrun), .cfg_err(cfg_err), .bit_lat(bit_lat)
);

// File: tb/test_ccd_drive_tg.sv
`timescale 1ns/1ps
module test_ccd_drive_tg;

    localparam int D = 8, O = 16, L = 8, V = 32, T = 4;
    localparam int HOLD = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_start = 1'b0;
    logic [1:0]  cfg_res = 2'd0;
    logic        cfg_bitclamp = 1'b1;
    logic [7:0]  cfg_half = 8'd24;
    logic [15:0] cfg_tg = 16'd1000;
    logic [23:0] cfg_line = 24'd1;
    logic        sh_phi1, sh_phi2, sh_phi3, sh_phi4, rst_gate, clamp, xfer_gate;
    logic        res_sel, line_valid, overrun, cfg_err;
    logic [15:0] pix_idx;
    logic [2:0]  region;

    int checks = 0;
    int fails  = 0;
    int prev_res = 0;

    always #2.5 clk = ~clk;

    ccd_drive_tg #(
        .DUMMY_PIX(D), .OBLK_PIX(O), .LEAD_PIX(L), .VALID_PIX(V), .TRAIL_PIX(T)
    ) i_ccd_drive_tg (
        .clk(clk), .rst(rst), .line_start(line_start), .cfg_res(cfg_res),
        .cfg_bitclamp(cfg_bitclamp), .cfg_half(cfg_half), .cfg_tg(cfg_tg),
        .cfg_line(cfg_line), .sh_phi1(sh_phi1), .sh_phi2(sh_phi2),
        .sh_phi3(sh_phi3), .sh_phi4(sh_phi4), .rst_gate(rst_gate),
        .clamp(clamp), .xfer_gate(xfer_gate), .res_sel(res_sel),
        .pix_idx(pix_idx), .region(region), .line_valid(line_valid),
        .overrun(overrun), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sc(input int base, input int res);
        int v;
        v = base >> res;
        return (v == 0) ? 1 : v;
    endfunction

    task automatic run_line(input int res, input bit bitc, input int half,
                            input int tg, input bit poke);
        int e, nd, no, nl, nv, nt, n, rd, total, unit;
        int c_tgbad = 0, c_hold = 0, c_clpbad = 0;
        int c_dum = 0, c_ob = 0, c_inv = 0, c_val = 0, c_lv = 0;
        int r_rise = 0, c_rise = 0, p_rise = 0, c_lowrd = 0, pmax = 0, pix0 = -1;
        bit pr_rst = 1'b0, pr_clp = 1'b0, pr_phi = 1'b1, exp_blank, exp_clp;
        e  = 1 << res;
        nd = sc(D, res); no = sc(O, res); nl = sc(L, res);
        nv = sc(V, res); nt = sc(T, res);
        n  = nd + no + nl + nv + nt;
        rd = 2 * HOLD + tg;
        unit = e * half;
        total = rd + n * unit;
        exp_blank = (res != prev_res);
        prev_res = res;

        cfg_res = res[1:0]; cfg_bitclamp = bitc;
        cfg_half = half[7:0]; cfg_tg = tg[15:0];
        line_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        line_start = 1'b0;
        chk(res_sel == (res == 0), "R1", "res_sel level", res_sel, res == 0);

        for (int k = 0; k < total; k++) begin
            if (k > 0) @(negedge clk);
            if (poke && k == 60) line_start = 1'b1;
            if (poke && k == 61) begin
                line_start = 1'b0;
                chk(overrun == 1'b1, "R9", "overrun on early strobe", overrun, 1);
            end
            if (k < rd) begin
                if (xfer_gate != (k >= HOLD && k < HOLD + tg)) c_tgbad++;
                if (!(rst_gate && sh_phi1 && !sh_phi2 && region == 3'd0)) c_hold++;
                exp_clp = bitc ? 1'b1 : !(k >= HOLD && k < HOLD + tg);
                if (clamp != exp_clp) c_clpbad++;
            end else begin
                if (k == rd) pix0 = pix_idx;
                case (region)
                    3'd1: c_dum++;
                    3'd2: c_ob++;
                    3'd3: c_inv++;
                    3'd4: c_val++;
                    default: ;
                endcase
                if (line_valid) c_lv++;
                if (int'(pix_idx) > pmax) pmax = pix_idx;
                if (!clamp) c_lowrd++;
                if (k > rd) begin
                    if (rst_gate && !pr_rst) r_rise++;
                    if (clamp && !pr_clp) c_rise++;
                    if (sh_phi1 && !pr_phi) p_rise++;
                    if (sh_phi1 == sh_phi2 || sh_phi3 == sh_phi4) c_hold++;
                end
            end
            pr_rst = rst_gate; pr_clp = clamp; pr_phi = sh_phi1;
        end
        @(negedge clk);
        chk(region == 3'd0 && !xfer_gate && !rst_gate, "R2", "line ends on time",
            region, 0);
        chk(c_tgbad == 0, "R5", "transfer gate window/width errors", c_tgbad, 0);
        chk(c_hold == 0, "R4", "frozen/complementary phase errors", c_hold, 0);
        chk(c_clpbad == 0, "R6", "clamp level in guard window", c_clpbad, 0);
        chk(c_dum == nd * unit, "R2", "dummy clocks", c_dum, nd * unit);
        chk(c_ob == no * unit, "R2", "black clocks", c_ob, no * unit);
        chk(c_inv == (nl + nt) * unit, "R2", "invalid clocks", c_inv, (nl + nt) * unit);
        chk(c_val == nv * unit, "R2", "valid clocks", c_val, nv * unit);
        chk(r_rise == n - 1, "R3", "reset pulses after first slot", r_rise, n - 1);
        chk(p_rise == (n * e - 1) / 2, "R4", "phi1 rising edges", p_rise, (n * e - 1) / 2);
        chk(pix0 == 0 && pmax == n - 1, "R11", "last slot index", pmax, n - 1);
        if (bitc) chk(c_rise == n, "R7", "clamp pulses per line", c_rise, n);
        else      chk(c_lowrd == 0, "R7", "line clamp low in readout", c_lowrd, 0);
        chk(c_lv == (exp_blank ? 0 : nv * unit), "R8", "line_valid clocks", c_lv,
            exp_blank ? 0 : nv * unit);
    endtask

    task automatic try_reject(input int res, input int half, input int tg, input bit exp_err);
        int busy = 0;
        cfg_res = res[1:0]; cfg_half = half[7:0]; cfg_tg = tg[15:0];
        #1;
        chk(cfg_err == exp_err, "R10", "cfg_err for settings", cfg_err, exp_err);
        if (exp_err) begin
            @(negedge clk);
            line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
            chk(overrun == 1'b0, "R10", "no overrun on rejected strobe", overrun, 0);
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (xfer_gate || rst_gate || region != 3'd0) busy++;
            end
            chk(busy == 0, "R10", "rejected strobe started nothing", busy, 0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int r;
        int busy;
        int tot;
        r = $urandom(32'h1D0C);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!xfer_gate && !rst_gate && !clamp && sh_phi1 && !sh_phi2 && region == 3'd0
            && !line_valid && !overrun, "R12", "idle outputs after reset", xfer_gate, 0);
        chk(res_sel == 1'b1, "R1", "res_sel after reset", res_sel, 1);

        // resolution sequence: blanking only after a change
        run_line(0, 1'b1, 24, 1000, 1'b1);
        run_line(1, 1'b1, 23, 1200, 1'b0);
        run_line(1, 1'b0, 25, 1000, 1'b0);
        run_line(2, 1'b1, 23, 1500, 1'b0);
        run_line(3, 1'b0, 24, 1000, 1'b0);
        run_line(3, 1'b1, 23, 1100, 1'b0);
        run_line(0, 1'b0, 23, 1000, 1'b0);

        // limits
        try_reject(0, 22, 1000, 1'b1);
        try_reject(0, 23, 999, 1'b1);
        try_reject(0, 23, 10001, 1'b1);
        try_reject(0, 23, 1000, 1'b0);
        try_reject(3, 23, 10000, 1'b0);

        // line period: strobe after readout but inside the period
        tot = 2 * HOLD + 1000 + 68 * 23;
        cfg_line = 24'(tot + 300);
        run_line(0, 1'b1, 23, 1000, 1'b0);
        cfg_line = 24'd1;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        chk(overrun == 1'b1, "R9", "overrun inside line period", overrun, 1);
        busy = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (xfer_gate || rst_gate || region != 3'd0) busy++;
        end
        chk(busy == 0, "R9", "early strobe started nothing", busy, 0);
        repeat (400) @(negedge clk);
        run_line(0, 1'b1, 23, 1000, 1'b0);

        // random lines
        for (int i = 0; i < 6; i++) begin
            run_line($urandom_range(3, 0), 1'($urandom_range(1, 0)),
                     $urandom_range(30, 23), $urandom_range(2000, 1000), 1'b0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule